// File: doc/BRIEF.md
# Ethernet PHY Bring-Up and Link Mode Sequencer

This block takes an Ethernet PHY from power-on to a known link configuration without software help. After a start pulse it can search the management address space for the first PHY that answers. It then waits for any reset already in progress to finish, soft-resets the PHY and waits for that reset to clear. If the PHY runs auto-negotiation, the block waits for it to finish and then works out the best mode that both link partners share. The result is three flags: gigabit, 100 Mbit and full duplex. A MAC that cannot run at gigabit speed lowers a gigabit result.

All PHY register traffic goes through a management request stream to an external MDIO controller. A request (write flag, PHY address, register number, write data) is offered with `mreq_valid`. It stays unchanged until `mreq_ready` accepts it. Only one request is ever outstanding. Each accepted request, read or write, is closed by exactly one `mrsp_valid` pulse in a later cycle, which carries the read data. The response path has no back-pressure: the block always takes a response while it is waiting for one. Ignoring `mreq_ready` only stalls the sequence; it never corrupts it.

The resets and the auto-negotiation wait share one time budget, counted in clock cycles as `CLK_KHZ * TIMEOUT_MS`. The budget starts when the address search ends.

Top module: `phy_mode_seq`

## Requirements
- R1: A request held with `mreq_valid` high and `mreq_ready` low keeps all request fields unchanged into the next cycle. No new request is offered until the response for the previous one has arrived.
- R2: With `scan_en` high, register 0 is read at PHY addresses 0, 1, 2 and so on, in ascending order. The first address whose value is neither 0x0000 nor 0xFFFF is selected. If none of the 32 addresses qualifies, `def_addr` is selected. With `scan_en` low, `def_addr` is used directly. Every later request goes to the selected address, which is shown on `phy_addr`.
- R3: Register 0 is polled until bit 15 reads 0. It is then written with the value last read, with bit 15 set. It is then polled again until bit 15 reads 0.
- R4: If a register 0 poll still shows bit 15 set once the time budget has run out, the block raises `fail`, keeps `done` low and clears all three link flags.
- R5: If bit 12 of register 0 is clear after the reset, register 0 is written with 0x0000. The block then finishes with 10 Mbit half duplex (all flags low).
- R6: Otherwise register 1 is polled until bit 5 is set. If the budget runs out first, register 0 is read once more and the block finishes (not fails) with gigabit = bit 6 AND NOT bit 13, 100 Mbit = NOT bit 6 AND bit 13, and full duplex = bit 8.
- R7: When bit 8 of register 1 is set, registers 9 and 10 are read. Gigabit full duplex is picked when register 9 bit 9 and register 10 bit 11 are both set. Otherwise gigabit half duplex is picked when register 9 bit 8 and register 10 bit 10 are both set. On a gigabit-capable MAC a gigabit pick finishes the block without reading registers 4 and 5.
- R8: With no gigabit pick, registers 4 and 5 are read. The first mode in this order that has its bit set in both registers wins: 100 full (bit 8), 100 half (bit 7), 10 full (bit 6). If none matches, the result is 10 half.
- R9: If gigabit was picked but `gbit_mac` is low, registers 4 and 5 are still resolved as in R8. Gigabit and full duplex are then cleared, and register 0 is written with the 100 Mbit flag in bit 13 and all other bits 0.
- R10: `done` and `fail` are never high together. They hold until the next accepted start. A start accepted from idle, done or fail clears them and the link flags in the following cycle. A start pulse during a bring-up has no effect.
- R11: `link_gbit` and `link_100` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a bring-up (ignored while one runs) |
| scan_en | input | 1 | Search addresses 0..31 before bring-up |
| def_addr | input | 5 | PHY address used without search or when the search finds nothing |
| gbit_mac | input | 1 | MAC supports gigabit operation |
| mreq_valid | output | 1 | Management request offered |
| mreq_ready | input | 1 | Controller accepts the request |
| mreq_write | output | 1 | 1 = register write, 0 = register read |
| mreq_phy | output | 5 | PHY address of the request |
| mreq_reg | output | 5 | Register number of the request |
| mreq_wdata | output | 16 | Write data |
| mrsp_valid | input | 1 | Response pulse closing the outstanding request |
| mrsp_data | input | 16 | Read data of the response |
| phy_addr | output | 5 | Selected PHY address |
| link_gbit | output | 1 | Resolved gigabit mode |
| link_100 | output | 1 | Resolved 100 Mbit mode |
| link_full | output | 1 | Resolved full duplex |
| done | output | 1 | Bring-up finished with a mode |
| fail | output | 1 | PHY reset did not finish within the budget |

## Verification
A sequencer that takes a wrong branch or skips a wait shows up first on the request stream: a wrong register number, a wrong address or a missing write. It appears on the very next request, so a model PHY that watches the request order catches it within a few cycles. A wrong resolution or a stale captured register shows up only at the end, as a wrong flag triple beside `done`. For that reason every case compares the final flags and the final register 0 write against an independent model. A wrong timer appears as `fail` in place of `done`, or as a fallback taken when the negotiation actually completed.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  localparam int DW = 16;
  localparam int AW = 5;
  localparam int RW = 5;

  localparam logic [RW-1:0] REG_CTL  = 5'd0;
  localparam logic [RW-1:0] REG_STAT = 5'd1;
  localparam logic [RW-1:0] REG_LADV = 5'd4;
  localparam logic [RW-1:0] REG_LPRT = 5'd5;
  localparam logic [RW-1:0] REG_GADV = 5'd9;
  localparam logic [RW-1:0] REG_GPRT = 5'd10;

  localparam int CTL_RST    = 15;
  localparam int CTL_SPD_HI = 13;
  localparam int CTL_ANEN   = 12;
  localparam int CTL_FULL   = 8;
  localparam int CTL_SPD_LO = 6;
  localparam int STAT_EXT   = 8;
  localparam int STAT_ANOK  = 5;

  typedef enum logic [4:0] {
    S_IDLE, S_SCAN, S_PRE, S_RSTW, S_POST, S_FORCE, S_ANPOLL, S_TORD,
    S_GADV, S_GPRT, S_GDEC, S_LADV, S_LPRT, S_LDEC, S_DOWN, S_DONE, S_FAIL
  } seq_state_t;

  typedef struct packed {
    logic gbit;
    logic m100;
    logic full;
  } link_mode_t;
endpackage

// File: rtl/phy_mgmt_port.sv
module phy_mgmt_port
  import phy_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          op_wr,
  input  logic [AW-1:0] op_phy,
  input  logic [RW-1:0] op_reg,
  input  logic [DW-1:0] op_wdata,
  output logic          busy,
  output logic          xfer_done,
  output logic [DW-1:0] xfer_rdata,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_phy,
  output logic [RW-1:0] req_reg,
  output logic [DW-1:0] req_wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data
);
  logic wait_rsp;

  assign busy = req_valid | wait_rsp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid  <= 1'b0;
      wait_rsp   <= 1'b0;
      xfer_done  <= 1'b0;
      xfer_rdata <= '0;
      req_write  <= 1'b0;
      req_phy    <= '0;
      req_reg    <= '0;
      req_wdata  <= '0;
    end else begin
      xfer_done <= 1'b0;
      if (issue && !busy) begin
        req_valid <= 1'b1;
        req_write <= op_wr;
        req_phy   <= op_phy;
        req_reg   <= op_reg;
        req_wdata <= op_wdata;
      end
      if (req_valid && req_ready) begin
        req_valid <= 1'b0;
        wait_rsp  <= 1'b1;
      end
      if (wait_rsp && rsp_valid) begin
        wait_rsp   <= 1'b0;
        xfer_done  <= 1'b1;
        xfer_rdata <= rsp_data;
      end
    end
  end
endmodule

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  assign expired = (cnt >= LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr)
      cnt <= '0;
    else if (run && !expired)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/phy_mode_resolve.sv
module phy_mode_resolve
  import phy_seq_pkg::*;
(
  input  logic       ext_ok,
  input  logic [1:0] gadv,     // [1]=full cap, [0]=half cap (local)
  input  logic [1:0] gprt,     // [1]=full cap, [0]=half cap (partner)
  input  logic [2:0] ladv,     // [2]=100F [1]=100H [0]=10F
  input  logic [2:0] lprt,
  input  logic       gbit_mac,
  output logic       gig_pick,
  output logic       need_down,
  output link_mode_t res_mode
);
  logic [1:0] gcom;
  logic [2:0] lcom;
  logic       gig_full, sp, fd;

  assign gcom = gadv & gprt & {2{ext_ok}};
  assign lcom = ladv & lprt;

  assign gig_pick  = |gcom;
  assign gig_full  = gcom[1];
  assign need_down = gig_pick & ~gbit_mac;

  always_comb begin
    sp = 1'b0;
    fd = 1'b0;
    if (lcom[2]) begin
      sp = 1'b1; fd = 1'b1;
    end else if (lcom[1]) begin
      sp = 1'b1;
    end else if (lcom[0]) begin
      fd = 1'b1;
    end
  end

  always_comb begin
    if (gig_pick && gbit_mac)
      res_mode = '{gbit: 1'b1, m100: 1'b0, full: gig_full};
    else if (need_down)
      res_mode = '{gbit: 1'b0, m100: sp, full: 1'b0};
    else
      res_mode = '{gbit: 1'b0, m100: sp, full: fd};
  end
endmodule

// File: rtl/phy_mode_seq.sv
module phy_mode_seq
  import phy_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ    = 200000,
  parameter int unsigned TIMEOUT_MS = 3000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          scan_en,
  input  logic [AW-1:0] def_addr,
  input  logic          gbit_mac,
  output logic          mreq_valid,
  input  logic          mreq_ready,
  output logic          mreq_write,
  output logic [AW-1:0] mreq_phy,
  output logic [RW-1:0] mreq_reg,
  output logic [DW-1:0] mreq_wdata,
  input  logic          mrsp_valid,
  input  logic [DW-1:0] mrsp_data,
  output logic [AW-1:0] phy_addr,
  output logic          link_gbit,
  output logic          link_100,
  output logic          link_full,
  output logic          done,
  output logic          fail
);
  localparam int unsigned LIMIT = CLK_KHZ * TIMEOUT_MS;
  localparam logic [AW-1:0] LAST_ADDR = {AW{1'b1}};

  seq_state_t    state;
  logic          issued, running, start_acc, issue;
  logic          xfer_state, op_wr;
  logic [RW-1:0] op_reg;
  logic [DW-1:0] op_wdata;
  logic          port_busy, xfer_done, expired;
  logic [DW-1:0] d;
  logic [DW-1:0] ctl_q;
  logic          ext_q;
  logic [1:0]    gadv_q, gprt_q;
  logic [2:0]    ladv_q, lprt_q;
  logic [AW-1:0] addr_q;
  link_mode_t    mode_q, res_mode;
  logic          done_q, fail_q, gig_pick, need_down;

  assign running   = !(state inside {S_IDLE, S_DONE, S_FAIL});
  assign start_acc = start & ~running;

  always_comb begin
    xfer_state = 1'b1;
    op_wr      = 1'b0;
    op_reg     = REG_CTL;
    op_wdata   = '0;
    unique case (state)
      S_SCAN, S_PRE, S_POST, S_TORD: op_reg = REG_CTL;
      S_RSTW: begin
        op_wr    = 1'b1;
        op_wdata = ctl_q | (DW'(1) << CTL_RST);
      end
      S_FORCE:  op_wr = 1'b1;
      S_ANPOLL: op_reg = REG_STAT;
      S_GADV:   op_reg = REG_GADV;
      S_GPRT:   op_reg = REG_GPRT;
      S_LADV:   op_reg = REG_LADV;
      S_LPRT:   op_reg = REG_LPRT;
      S_DOWN: begin
        op_wr    = 1'b1;
        op_wdata = DW'(res_mode.m100) << CTL_SPD_HI;
      end
      default:  xfer_state = 1'b0;
    endcase
  end

  assign issue = xfer_state & ~issued & ~port_busy;

  phy_mgmt_port u_port (
    .clk, .rst_n, .issue, .op_wr, .op_phy(addr_q), .op_reg, .op_wdata,
    .busy(port_busy), .xfer_done, .xfer_rdata(d),
    .req_valid(mreq_valid), .req_ready(mreq_ready), .req_write(mreq_write),
    .req_phy(mreq_phy), .req_reg(mreq_reg), .req_wdata(mreq_wdata),
    .rsp_valid(mrsp_valid), .rsp_data(mrsp_data)
  );

  phy_seq_timer #(.LIMIT(LIMIT)) u_timer (
    .clk, .rst_n, .clr(start_acc || state == S_SCAN), .run(running), .expired
  );

  phy_mode_resolve u_res (
    .ext_ok(ext_q), .gadv(gadv_q), .gprt(gprt_q), .ladv(ladv_q), .lprt(lprt_q),
    .gbit_mac, .gig_pick, .need_down, .res_mode
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      issued <= 1'b0;
      addr_q <= '0;
      ctl_q  <= '0;
      ext_q  <= 1'b0;
      gadv_q <= '0;
      gprt_q <= '0;
      ladv_q <= '0;
      lprt_q <= '0;
      mode_q <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else if (start_acc) begin
      state  <= scan_en ? S_SCAN : S_PRE;
      addr_q <= scan_en ? '0 : def_addr;
      issued <= 1'b0;
      ctl_q  <= '0;
      ext_q  <= 1'b0;
      gadv_q <= '0;
      gprt_q <= '0;
      ladv_q <= '0;
      lprt_q <= '0;
      mode_q <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      if (issue) issued <= 1'b1;
      if (state == S_GDEC) begin
        if (gig_pick && gbit_mac) begin
          mode_q <= res_mode; done_q <= 1'b1; state <= S_DONE;
        end else
          state <= S_LADV;
      end
      if (state == S_LDEC) begin
        if (need_down) state <= S_DOWN;
        else begin
          mode_q <= res_mode; done_q <= 1'b1; state <= S_DONE;
        end
      end
      if (xfer_done) begin
        issued <= 1'b0;
        unique case (state)
          S_SCAN: begin
            if (d != '0 && d != '1) state <= S_PRE;
            else if (addr_q == LAST_ADDR) begin
              addr_q <= def_addr;
              state  <= S_PRE;
            end else
              addr_q <= addr_q + 1'b1;
          end
          S_PRE: begin
            if (!d[CTL_RST]) begin
              ctl_q <= d;
              state <= S_RSTW;
            end else if (expired) begin
              fail_q <= 1'b1; state <= S_FAIL;
            end
          end
          S_RSTW: state <= S_POST;
          S_POST: begin
            if (!d[CTL_RST]) begin
              ctl_q <= d;
              state <= d[CTL_ANEN] ? S_ANPOLL : S_FORCE;
            end else if (expired) begin
              fail_q <= 1'b1; state <= S_FAIL;
            end
          end
          S_FORCE: begin
            mode_q <= '0; done_q <= 1'b1; state <= S_DONE;
          end
          S_ANPOLL: begin
            if (d[STAT_ANOK]) begin
              ext_q <= d[STAT_EXT];
              state <= d[STAT_EXT] ? S_GADV : S_LADV;
            end else if (expired)
              state <= S_TORD;
          end
          S_TORD: begin
            mode_q <= '{gbit: d[CTL_SPD_LO] & ~d[CTL_SPD_HI],
                        m100: ~d[CTL_SPD_LO] & d[CTL_SPD_HI],
                        full: d[CTL_FULL]};
            done_q <= 1'b1;
            state  <= S_DONE;
          end
          S_GADV: begin gadv_q <= d[9:8];   state <= S_GPRT; end
          S_GPRT: begin gprt_q <= d[11:10]; state <= S_GDEC; end
          S_LADV: begin ladv_q <= d[8:6];   state <= S_LPRT; end
          S_LPRT: begin lprt_q <= d[8:6];   state <= S_LDEC; end
          S_DOWN: begin
            mode_q <= res_mode; done_q <= 1'b1; state <= S_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  assign phy_addr  = addr_q;
  assign link_gbit = mode_q.gbit;
  assign link_100  = mode_q.m100;
  assign link_full = mode_q.full;
  assign done      = done_q;
  assign fail      = fail_q;
endmodule

// File: rtl/phy_mode_seq_chk.sv
module phy_mode_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mreq_valid,
  input logic        mreq_ready,
  input logic        mreq_write,
  input logic [4:0]  mreq_phy,
  input logic [4:0]  mreq_reg,
  input logic [15:0] mreq_wdata,
  input logic        mrsp_valid,
  input logic        link_gbit,
  input logic        link_100,
  input logic        link_full,
  input logic        done,
  input logic        fail
);
  logic outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outstanding <= 1'b0;
    else if (mreq_valid && mreq_ready) outstanding <= 1'b1;
    else if (mrsp_valid) outstanding <= 1'b0;
  end

  a_r1_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready |=> mreq_valid &&
      $stable({mreq_write, mreq_phy, mreq_reg, mreq_wdata}));

  a_r1_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !mreq_valid);

  a_r10_done_fail_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  a_r10_quiet_when_finished: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> !mreq_valid);

  a_r4_fail_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !(link_gbit || link_100 || link_full));

  a_r11_one_speed: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({link_gbit, link_100}));
endmodule

bind phy_mode_seq phy_mode_seq_chk u_chk (
  .clk, .rst_n, .mreq_valid, .mreq_ready, .mreq_write, .mreq_phy, .mreq_reg,
  .mreq_wdata, .mrsp_valid, .link_gbit, .link_100, .link_full, .done, .fail
);

// File: tb/phy_mode_seq_test.sv
`timescale 1ns/1ps
module phy_mode_seq_test;
  localparam int NEVER = 1000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, scan_en = 1'b0, gbit_mac = 1'b0;
  logic [4:0] def_addr = '0;
  logic mreq_valid, mreq_write;
  logic mreq_ready = 1'b0;
  logic [4:0] mreq_phy, mreq_reg;
  logic [15:0] mreq_wdata;
  logic mrsp_valid = 1'b0;
  logic [15:0] mrsp_data = '0;
  logic [4:0] phy_addr;
  logic link_gbit, link_100, link_full, done, fail;

  always #2.5 clk = ~clk;

  phy_mode_seq #(.CLK_KHZ(1), .TIMEOUT_MS(1500)) uut (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  // model PHY state
  bit scanning; int scan_idx, hide_cnt, pre_left, rst_left, rst_len, an_left;
  logic [4:0] at_addr, exp_addr;
  logic [15:0] m_ctl, m_g9, m_g10, m_a4, m_a5;
  bit m_ext;
  int wr_cnt; logic [15:0] last_wr, rst_wr; bit rst_seen;
  int viol = 0, addr_bad = 0, order_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_txn(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, output logic [15:0] rd);
    rd = 16'h0;
    if (scanning && !wr && rg == 0) begin
      if (phy != scan_idx[4:0]) order_bad++;
      scan_idx++;
    end else if (phy != exp_addr) addr_bad++;
    if (wr) begin
      if (rg == 0 && wd[15]) begin rst_wr = wd; rst_seen = 1; rst_left = rst_len; end
      else if (rg == 0) begin wr_cnt++; last_wr = wd; end
    end else if (rg == 0 && hide_cnt > 0) begin
      hide_cnt--; rd = 16'hFFFF;
    end else if (phy != at_addr) begin
      rd = phy[0] ? 16'hFFFF : 16'h0000;
    end else begin
      case (rg)
        5'd0: if (pre_left > 0) begin pre_left--; rd = m_ctl | 16'h8000; end
              else if (rst_left > 0) begin rst_left--; rd = m_ctl | 16'h8000; end
              else rd = m_ctl;
        5'd1: begin
          rd = {7'b0, m_ext, 8'h09};
          if (an_left > 0) an_left--; else rd[5] = 1'b1;
        end
        5'd4: rd = m_a4;
        5'd5: rd = m_a5;
        5'd9: rd = m_g9;
        5'd10: rd = m_g10;
        default: rd = 16'h0;
      endcase
    end
    if (scanning && (scan_idx == 32 || (rd != 16'h0 && rd != 16'hFFFF && !wr && rg == 0)))
      scanning = 0;
  endtask

  // responder: drives mreq_ready / mrsp_*
  initial begin
    int pend = 0;
    logic [15:0] rdv, hold;
    bit pv = 0, pr = 0;
    logic [26:0] pf = '0;
    forever begin
      @(negedge clk);
      if (pv && !pr && (!mreq_valid || pf != {mreq_write, mreq_phy, mreq_reg, mreq_wdata}))
        viol++;  // R1
      mrsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin mrsp_valid = 1'b1; mrsp_data = hold; end
      end
      if (mreq_valid && pend > 0) viol++;  // R1
      mreq_ready = ($urandom % 3) != 0;
      if (mreq_valid && mreq_ready && pend == 0) begin
        model_txn(mreq_write, mreq_phy, mreq_reg, mreq_wdata, rdv);
        hold = rdv;
        pend = 1 + $urandom % 3;
      end
      pv = mreq_valid; pr = mreq_ready;
      pf = {mreq_write, mreq_phy, mreq_reg, mreq_wdata};
    end
  end

  function automatic void expect_mode(input logic [15:0] ctl, input bit an_never,
      input bit ext, input logic [15:0] g9, g10, a4, a5, input bit mac,
      output bit gb, output bit sp, output bit fd, output int wcnt, output logic [15:0] wval);
    gb = 0; sp = 0; fd = 0; wcnt = 0; wval = 0;
    if (!ctl[12]) begin wcnt = 1; wval = 0; return; end
    if (an_never) begin
      gb = ctl[6] & ~ctl[13]; sp = ~ctl[6] & ctl[13]; fd = ctl[8]; return;
    end
    if (ext) begin
      if (g9[9] && g10[11]) begin gb = 1; fd = 1; end
      else if (g9[8] && g10[10]) begin gb = 1; fd = 0; end
    end
    if (gb && mac) return;
    if (a4[8] && a5[8]) begin sp = 1; fd = 1; end
    else if (a4[7] && a5[7]) begin sp = 1; fd = 0; end
    else if (a4[6] && a5[6]) begin sp = 0; fd = 1; end
    else if (!gb) begin sp = 0; fd = 0; end
    if (gb) begin gb = 0; fd = 0; wcnt = 1; wval = {2'b0, sp, 13'b0}; end
  endfunction

  task automatic run_case(input string tag, input bit sc, input bit hide,
      input logic [4:0] at, input logic [4:0] dflt, input logic [15:0] ctl,
      input int pre, input int rlen, input int anlen, input bit ext,
      input logic [15:0] g9, g10, a4, a5, input bit mac, input bit poke);
    bit gb, sp, fd, exp_fail; int wcnt; logic [15:0] wval; int cyc;
    scanning = sc; scan_idx = 0; hide_cnt = hide ? 32 : 0;
    at_addr = (sc && !hide) ? at : dflt; exp_addr = at_addr;
    m_ctl = ctl; pre_left = pre; rst_left = 0; rst_len = rlen; an_left = anlen;
    m_ext = ext; m_g9 = g9; m_g10 = g10; m_a4 = a4; m_a5 = a5;
    wr_cnt = 0; last_wr = 0; rst_seen = 0; rst_wr = 0;
    @(negedge clk);
    scan_en = sc; def_addr = dflt; gbit_mac = mac; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!done && !fail && !link_gbit && !link_100 && !link_full, "R10",
          {tag, " cleared after start"}, {done, fail}, 0);
    cyc = 0;
    while (!done && !fail && cyc < 20000) begin
      @(negedge clk); cyc++;
      if (poke && cyc == 20) begin start = 1'b1; def_addr = dflt ^ 5'h1F; end
      if (poke && cyc == 21) begin start = 1'b0; def_addr = dflt; end
    end
    check(cyc < 20000, "R10", {tag, " finished"}, cyc, 0);
    exp_fail = (rlen >= NEVER);
    expect_mode(ctl, anlen >= NEVER, ext, g9, g10, a4, a5, mac, gb, sp, fd, wcnt, wval);
    if (exp_fail) begin
      check(fail && !done, "R4", {tag, " fail"}, {done, fail}, 1);
      check({link_gbit, link_100, link_full} == 3'b0, "R4", {tag, " flags"},
            {link_gbit, link_100, link_full}, 0);
    end else begin
      check(done && !fail, "R10", {tag, " done"}, {done, fail}, 2);
      check({link_gbit, link_100, link_full} == {gb, sp, fd}, "R7 R8 R9 R6 R5",
            {tag, " flags"}, {link_gbit, link_100, link_full}, {gb, sp, fd});
      check(wr_cnt == wcnt && (wcnt == 0 || last_wr == wval), "R5 R9",
            {tag, " final ctl write"}, last_wr, wval);
    end
    check(phy_addr == exp_addr, "R2", {tag, " address"}, phy_addr, exp_addr);
    check(rst_seen && rst_wr == (ctl | 16'h8000), "R3", {tag, " reset write"},
          rst_wr, ctl | 16'h8000);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(negedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !fail && !mreq_valid && !link_gbit && !link_100 && !link_full,
          "R10", "reset state", {done, fail, mreq_valid}, 0);
    // R7 gig full with gig MAC
    run_case("gfull", 0, 0, 0, 5'd3, 16'h1141, 1, 2, 2, 1, 16'h0300, 16'h0C00, 16'h01C0, 16'h01C0, 1, 0);
    // R7 gig half only
    run_case("ghalf", 0, 0, 0, 5'd4, 16'h1001, 0, 1, 0, 1, 16'h0100, 16'h0C00, 16'h0, 16'h0, 1, 0);
    // R9 downgrade with 100 full common
    run_case("down100", 0, 0, 0, 5'd5, 16'h1001, 0, 0, 1, 1, 16'h0200, 16'h0800, 16'h0100, 16'h0100, 0, 0);
    // R9 downgrade with nothing common
    run_case("down10", 0, 0, 0, 5'd6, 16'h1001, 0, 0, 1, 1, 16'h0200, 16'h0800, 16'h0100, 16'h0080, 0, 0);
    // R8 100 half beats 10 full
    run_case("h100", 0, 0, 0, 5'd7, 16'h1001, 0, 0, 0, 0, 16'h0300, 16'h0C00, 16'h00C0, 16'h00C0, 1, 0);
    // R8 10 full only
    run_case("f10", 0, 0, 0, 5'd8, 16'h1001, 0, 0, 0, 0, 16'h0, 16'h0, 16'h0140, 16'h0040, 1, 0);
    // R5 auto-negotiation disabled
    run_case("noan", 0, 0, 0, 5'd9, 16'h2141, 2, 1, 0, 1, 16'h0300, 16'h0C00, 16'h0100, 16'h0100, 1, 0);
    // R6 negotiation timeout fallbacks
    run_case("to_g", 0, 0, 0, 5'd10, 16'h1141, 0, 0, NEVER, 1, 16'h0, 16'h0, 16'h0, 16'h0, 1, 0);
    run_case("to_100", 0, 0, 0, 5'd11, 16'h3001, 0, 0, NEVER, 0, 16'h0, 16'h0, 16'h0, 16'h0, 1, 0);
    // R4 reset never clears
    run_case("rstfail", 0, 0, 0, 5'd12, 16'h1001, 0, NEVER, 0, 0, 16'h0, 16'h0, 16'h0, 16'h0, 1, 0);
    // R2 scan finds address 17, then scan with nothing found
    run_case("scan17", 1, 0, 5'd17, 5'd2, 16'h1001, 1, 1, 1, 0, 16'h0, 16'h0, 16'h0100, 16'h0100, 1, 0);
    run_case("scannone", 1, 1, 5'd0, 5'd21, 16'h1001, 0, 1, 0, 0, 16'h0, 16'h0, 16'h0080, 16'h0080, 1, 0);
    // R10 start during a run is ignored
    run_case("poke", 0, 0, 0, 5'd13, 16'h1001, 2, 3, 3, 0, 16'h0, 16'h0, 16'h0100, 16'h0100, 1, 1);
    for (int i = 0; i < 30; i++) begin
      bit sc = $urandom % 2;
      bit hide = sc && ($urandom % 4 == 0);
      logic [15:0] ctl = (16'($urandom) & 16'h71C0) | 16'h0001;
      int an = ($urandom % 8 == 0) ? NEVER : int'($urandom % 5);
      run_case("rand", sc, hide, 5'($urandom), 5'($urandom), ctl,
               int'($urandom % 3), int'($urandom % 4), an, 1'($urandom),
               16'($urandom) & 16'h0300, 16'($urandom) & 16'h0C00,
               16'($urandom) & 16'h01C0, 16'($urandom) & 16'h01C0, 1'($urandom), 0);
    end
    check(viol == 0, "R1", "request stream protocol", viol, 0);
    check(order_bad == 0, "R2", "ascending scan order", order_bad, 0);
    check(addr_bad == 0, "R2", "requests to selected address", addr_bad, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule